// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block decides, once per clock, which of five UART interrupt sources the CPU should be told about, and produces a 4-bit identification code plus a level interrupt request. The five sources are receiver line errors, receive data at or above a trigger level, receive character timeout, transmit holding empty, and modem status change. The block works from the interrupt-enable bits, the line and modem status flags, the receive FIFO occupancy and a frame time supplied by the surrounding UART.

Two pieces of state live inside the block. The first is the transmit-empty pending flag. It is armed when the holding buffer drains and disarmed by a holding-register write, or by a read of the identification byte while that source is the one reported. The second is the character-timeout counter. It counts while received data waits, restarts on every receive push or pop, and is compared with a threshold of a fixed number of frame times. The identification code is registered, so it shows the sources as they stood at the previous clock edge.

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is asserted, and at the first edge after it is released, `irq_code` is 4'b0001 (no interrupt) and `irq` is low.
- R2: Codes are 0110 line status, 0100 receive data, 1100 timeout, 0010 transmit empty, 0000 modem and 0001 none. When several sources are active, the highest-ranked one wins, in the order line, receive data, timeout, transmit empty, modem. The code is registered: it shows the inputs and flags sampled at the preceding clock edge.
- R3: The line source is active when `ien[2]` is set and any bit of `ls_err` is set (bit 0 overrun, bit 1 parity, bit 2 framing, bit 3 break).
- R4: The receive-data source is active when `ien[0]` and `data_ready` are set and `rx_count` is at least the trigger level. In FIFO mode, `trig_sel` values 0, 1, 2 and 3 select levels 1, 4, 8 and 14. In character mode the level is 1.
- R5: The timeout counter clears on an `rx_push` or `rx_pop` pulse and otherwise increments, saturating, only while `data_ready` is high. The timeout source is active when `ien[0]` is set, `rx_count` is nonzero and the counter is at least TMO_MULT (default 4) times `frame_time`.
- R6: A `tx_empty_evt` pulse sets the transmit-empty pending flag. A `thr_write` pulse clears it, and a write wins over an empty event in the same cycle. The source is active when `ien[1]` is set and the flag is set.
- R7: An `id_read` pulse clears the transmit-empty flag only while `irq_code` reports transmit empty. A read while another code is reported leaves the flag unchanged.
- R8: One cycle after reset is released, and on a `tx_flush` pulse, the transmit-empty flag takes the value of `fifo_mode`. A flush overrides all other flag events.
- R9: The modem source is active when `ien[3]` is set and any bit of `ms_delta` is set.
- R10: `irq` is high exactly when `irq_code` is not 0001. `id_byte` is `{2'b11, 2'b00, irq_code}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode | input | 1 | 1 = 16-entry FIFO mode, 0 = character mode |
| trig_sel | input | 2 | Receive trigger level select |
| ien | input | 4 | Enables: [0] receive/timeout, [1] transmit empty, [2] line, [3] modem |
| ls_err | input | 4 | Line error flags: overrun, parity, framing, break |
| ms_delta | input | 4 | Modem change flags |
| data_ready | input | 1 | Receive data waiting |
| rx_count | input | CNT_W (5) | Receive FIFO occupancy |
| rx_push | input | 1 | Pulse: a character entered the receive FIFO |
| rx_pop | input | 1 | Pulse: a character was read from the receive FIFO |
| frame_time | input | FT_W (12) | Clock ticks per character frame |
| tx_empty_evt | input | 1 | Pulse: the transmit holding buffer went from full to empty |
| thr_write | input | 1 | Pulse: the holding register was written |
| tx_flush | input | 1 | Pulse: the transmit side was flushed |
| id_read | input | 1 | Pulse: the identification byte was read |
| irq_code | output | 4 | Registered identification code |
| id_byte | output | 8 | Identification byte as read by software |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- a line error with its enable set is reported at the next edge;
- the receive-data, timeout and modem codes appear only when their enable and their qualifying inputs were present one edge earlier;
- a holding-register write stops the transmit-empty code within two edges.

Only the bench scenarios can show the full priority resolution across every mix of sources, and the exact cycle on which the timeout counter reaches its threshold. The same holds for the conditional effect of reading the identification byte, and for the value the transmit-empty flag takes after reset or a flush in each mode.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
package uart_irq_pkg;

  typedef enum logic [3:0] {
    ID_MODEM   = 4'b0000,
    ID_NONE    = 4'b0001,
    ID_TXEMPTY = 4'b0010,
    ID_RXDATA  = 4'b0100,
    ID_LINE    = 4'b0110,
    ID_TIMEOUT = 4'b1100
  } irq_id_e;

  localparam int EN_RX    = 0;
  localparam int EN_TX    = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;

  // source vector positions, highest rank first
  localparam int SRC_LINE  = 0;
  localparam int SRC_RXD   = 1;
  localparam int SRC_TMO   = 2;
  localparam int SRC_TXE   = 3;
  localparam int SRC_MODEM = 4;
  localparam int N_SRC     = 5;

  function automatic int unsigned trig_level(input logic [1:0] sel, input logic fifo_on);
    if (!fifo_on) return 1;
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/irq_thre_flag.sv
`timescale 1ns/1ps
module irq_thre_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_mode,
  input  logic tx_empty_evt,
  input  logic thr_write,
  input  logic tx_flush,
  input  logic id_read,
  input  logic reported,
  output logic pend
);

  logic boot_q, boot_d;
  logic pend_q, pend_d;

  always_comb begin
    boot_d = 1'b0;
    pend_d = pend_q;
    if (tx_flush)
      pend_d = fifo_mode;
    else if (thr_write)
      pend_d = 1'b0;
    else if (boot_q)
      pend_d = fifo_mode;
    else if (tx_empty_evt)
      pend_d = 1'b1;
    else if (id_read && reported)
      pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      boot_q <= boot_d;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

endmodule

// File: rtl/irq_timeout_ctr.sv
`timescale 1ns/1ps
module irq_timeout_ctr #(
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_ready,
  input  logic          restart,
  input  logic [CW-1:0] limit,
  output logic          expired
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = data_ready && (cnt_q != {CW{1'b1}});
    cnt_d  = cnt_q;
    if (restart)
      cnt_d = '0;
    else if (cnt_en)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign expired = (cnt_q >= limit);

endmodule

// File: rtl/irq_prio_enc.sv
`timescale 1ns/1ps
module irq_prio_enc
  import uart_irq_pkg::*;
(
  input  logic [N_SRC-1:0] src,
  output irq_id_e          code
);

  always_comb begin
    if (src[SRC_LINE])
      code = ID_LINE;
    else if (src[SRC_RXD])
      code = ID_RXDATA;
    else if (src[SRC_TMO])
      code = ID_TIMEOUT;
    else if (src[SRC_TXE])
      code = ID_TXEMPTY;
    else if (src[SRC_MODEM])
      code = ID_MODEM;
    else
      code = ID_NONE;
  end

endmodule

// File: rtl/uart_irq_ident.sv
`timescale 1ns/1ps
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int FT_W     = 12,
  parameter int TMO_MULT = 4,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int CW      = FT_W + $clog2(TMO_MULT) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_mode,
  input  logic [1:0]       trig_sel,
  input  logic [3:0]       ien,
  input  logic [3:0]       ls_err,
  input  logic [3:0]       ms_delta,
  input  logic             data_ready,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic [FT_W-1:0]  frame_time,
  input  logic             tx_empty_evt,
  input  logic             thr_write,
  input  logic             tx_flush,
  input  logic             id_read,
  output logic [3:0]       irq_code,
  output logic [7:0]       id_byte,
  output logic             irq
);

  irq_id_e          code_q, code_d;
  logic [N_SRC-1:0] src;
  logic             thre_pend;
  logic             tmo_hit;
  logic [CW-1:0]    tmo_limit;
  logic [CNT_W-1:0] level;

  assign tmo_limit = CW'(frame_time) * CW'(TMO_MULT);
  assign level     = CNT_W'(trig_level(trig_sel, fifo_mode));

  irq_thre_flag u_thre (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_mode    (fifo_mode),
    .tx_empty_evt (tx_empty_evt),
    .thr_write    (thr_write),
    .tx_flush     (tx_flush),
    .id_read      (id_read),
    .reported     (code_q == ID_TXEMPTY),
    .pend         (thre_pend)
  );

  irq_timeout_ctr #(.CW(CW)) u_tmo (
    .clk        (clk),
    .rst_n      (rst_n),
    .data_ready (data_ready),
    .restart    (rx_push || rx_pop),
    .limit      (tmo_limit),
    .expired    (tmo_hit)
  );

  always_comb begin
    src            = '0;
    src[SRC_LINE]  = ien[EN_LINE] && (|ls_err);
    src[SRC_RXD]   = ien[EN_RX] && data_ready && (rx_count >= level);
    src[SRC_TMO]   = ien[EN_RX] && (rx_count != '0) && tmo_hit;
    src[SRC_TXE]   = ien[EN_TX] && thre_pend;
    src[SRC_MODEM] = ien[EN_MODEM] && (|ms_delta);
  end

  irq_prio_enc u_enc (
    .src  (src),
    .code (code_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      code_q <= ID_NONE;
    else
      code_q <= code_d;
  end

  assign irq_code = code_q;
  assign id_byte  = {2'b11, 2'b00, code_q};
  assign irq      = (code_q != ID_NONE);

endmodule

// File: rtl/uart_irq_ident_chk.sv
`timescale 1ns/1ps
module uart_irq_ident_chk
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       ien,
  input logic [3:0]       ls_err,
  input logic [3:0]       ms_delta,
  input logic             data_ready,
  input logic [CNT_W-1:0] rx_count,
  input logic             thr_write,
  input logic             tx_flush,
  input logic [3:0]       irq_code
);

  // R3: an enabled line error is reported at the next edge
  a_r3_line_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ien[EN_LINE] && (|ls_err)) |=> (irq_code == ID_LINE));

  // R4: the receive-data code needs enable and waiting data one edge before
  a_r4_rxdata_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_code == ID_RXDATA) |-> $past(ien[EN_RX] && data_ready && (rx_count != '0)));

  // R5: the timeout code needs enable and a non-empty buffer
  a_r5_timeout_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_code == ID_TIMEOUT) |-> $past(ien[EN_RX] && (rx_count != '0)));

  // R6: a holding write stops the transmit-empty code within two edges
  a_r6_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_write && !tx_flush) |-> ##2 (irq_code != ID_TXEMPTY));

  // R9: the modem code needs enable and a change flag
  a_r9_modem_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_code == ID_MODEM) |-> $past(ien[EN_MODEM] && (|ms_delta)));

endmodule

bind uart_irq_ident uart_irq_ident_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ien        (ien),
  .ls_err     (ls_err),
  .ms_delta   (ms_delta),
  .data_ready (data_ready),
  .rx_count   (rx_count),
  .thr_write  (thr_write),
  .tx_flush   (tx_flush),
  .irq_code   (irq_code)
);

// File: tb/sim_uart_irq_ident.sv
`timescale 1ns/1ps
module sim_uart_irq_ident;

  localparam int CLK_P = 10;
  localparam int CNT_W = 5;
  localparam int FT_W  = 12;

  localparam logic [3:0] C_NONE = 4'b0001;
  localparam logic [3:0] C_LINE = 4'b0110;
  localparam logic [3:0] C_RXD  = 4'b0100;
  localparam logic [3:0] C_TMO  = 4'b1100;
  localparam logic [3:0] C_TXE  = 4'b0010;
  localparam logic [3:0] C_MOD  = 4'b0000;

  logic             clk;
  logic             rst_n;
  logic             fifo_mode;
  logic [1:0]       trig_sel;
  logic [3:0]       ien;
  logic [3:0]       ls_err;
  logic [3:0]       ms_delta;
  logic             data_ready;
  logic [CNT_W-1:0] rx_count;
  logic             rx_push;
  logic             rx_pop;
  logic [FT_W-1:0]  frame_time;
  logic             tx_empty_evt;
  logic             thr_write;
  logic             tx_flush;
  logic             id_read;
  logic [3:0]       irq_code;
  logic [7:0]       id_byte;
  logic             irq;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  uart_irq_ident u0 (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .trig_sel(trig_sel),
    .ien(ien), .ls_err(ls_err), .ms_delta(ms_delta), .data_ready(data_ready),
    .rx_count(rx_count), .rx_push(rx_push), .rx_pop(rx_pop),
    .frame_time(frame_time), .tx_empty_evt(tx_empty_evt), .thr_write(thr_write),
    .tx_flush(tx_flush), .id_read(id_read), .irq_code(irq_code),
    .id_byte(id_byte), .irq(irq)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_P/2) clk = ~clk;
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  function automatic logic [3:0] model(input logic [3:0] en, input logic [3:0] ls,
                                       input logic [3:0] ms, input logic rdy,
                                       input int cnt, input int lvl,
                                       input logic tmo, input logic txf);
    if (en[2] && ls != 0)              return C_LINE;
    if (en[0] && rdy && cnt >= lvl)    return C_RXD;
    if (en[0] && cnt != 0 && tmo)      return C_TMO;
    if (en[1] && txf)                  return C_TXE;
    if (en[3] && ms != 0)              return C_MOD;
    return C_NONE;
  endfunction

  initial begin
    #(CLK_P*200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fifo_mode = 1'b0; trig_sel = 2'd0; ien = 4'h0; ls_err = 4'h0;
    ms_delta = 4'h0; data_ready = 1'b0; rx_count = '0; rx_push = 1'b0; rx_pop = 1'b0;
    frame_time = '1; tx_empty_evt = 1'b0; thr_write = 1'b0; tx_flush = 1'b0; id_read = 1'b0;

    // R1: reset state, with transmit-empty enabled
    ien = 4'b0010;
    #(CLK_P*2 + 3);
    chk("R1 code in reset", {4'h0, irq_code}, {4'h0, C_NONE});
    chk("R1 irq in reset", {7'h0, irq}, 8'h0);
    rst_n = 1'b1;
    tick();
    chk("R1 first edge", {4'h0, irq_code}, {4'h0, C_NONE});
    tick(); tick();
    chk("R8 char mode after reset", {4'h0, irq_code}, {4'h0, C_NONE});

    // R8: reset in FIFO mode arms transmit empty
    rst_n = 1'b0; fifo_mode = 1'b1;
    #(CLK_P);
    rst_n = 1'b1;
    tick(); tick(); tick();
    chk("R8 fifo mode after reset", {4'h0, irq_code}, {4'h0, C_TXE});
    chk("R10 irq high", {7'h0, irq}, 8'h1);
    chk("R10 id byte", id_byte, {4'b1100, C_TXE});

    // R6: write clears, empty event sets
    fifo_mode = 1'b0;
    thr_write = 1'b1; tick(); thr_write = 1'b0; tick();
    chk("R6 write clears", {4'h0, irq_code}, {4'h0, C_NONE});
    tx_empty_evt = 1'b1; tick(); tx_empty_evt = 1'b0; tick();
    chk("R6 empty event sets", {4'h0, irq_code}, {4'h0, C_TXE});
    thr_write = 1'b1; tx_empty_evt = 1'b1; tick();
    thr_write = 1'b0; tx_empty_evt = 1'b0; tick();
    chk("R6 write beats empty event", {4'h0, irq_code}, {4'h0, C_NONE});

    // R7: a read clears only while transmit empty is reported
    tx_empty_evt = 1'b1; tick(); tx_empty_evt = 1'b0; tick();
    ien = 4'b0110; ls_err = 4'b1000; tick();
    chk("R3 break outranks tx empty", {4'h0, irq_code}, {4'h0, C_LINE});
    id_read = 1'b1; tick(); id_read = 1'b0; ls_err = 4'h0; tick();
    chk("R7 read during line keeps flag", {4'h0, irq_code}, {4'h0, C_TXE});
    id_read = 1'b1; tick(); id_read = 1'b0; tick();
    chk("R7 read while reported clears", {4'h0, irq_code}, {4'h0, C_NONE});
    chk("R10 irq low", {7'h0, irq}, 8'h0);

    // R8: flush loads fifo_mode
    fifo_mode = 1'b1; tx_flush = 1'b1; thr_write = 1'b1; tick();
    tx_flush = 1'b0; thr_write = 1'b0; tick();
    chk("R8 flush in fifo mode", {4'h0, irq_code}, {4'h0, C_TXE});
    fifo_mode = 1'b0; tx_flush = 1'b1; tick(); tx_flush = 1'b0; tick();
    chk("R8 flush in char mode", {4'h0, irq_code}, {4'h0, C_NONE});

    // R2, R3, R9: priority sweep, counter held at zero by push
    fifo_mode = 1'b1; trig_sel = 2'd1; rx_push = 1'b1; frame_time = 12'd1;
    for (int ph = 0; ph < 2; ph++) begin
      ien = 4'h0;
      if (ph == 0) thr_write = 1'b1; else tx_empty_evt = 1'b1;
      tick(); thr_write = 1'b0; tx_empty_evt = 1'b0;
      for (int e = 0; e < 16; e++)
        for (int li = 0; li < 5; li++)
          for (int mi = 0; mi < 5; mi++)
            for (int ci = 0; ci < 4; ci++) begin
              int cnt;
              logic [3:0] ev;
              cnt = (ci == 3) ? 4 : ci;
              ien = 4'(e);
              ls_err = (li == 0) ? 4'h0 : 4'(1 << (li - 1));
              ms_delta = (mi == 0) ? 4'h0 : 4'(1 << (mi - 1));
              rx_count = CNT_W'(cnt);
              data_ready = (cnt != 0);
              tick();
              ev = model(ien, ls_err, ms_delta, data_ready, cnt, 4, 1'b0, ph == 1);
              chk("R2 R3 R9 priority sweep", {4'h0, irq_code}, {4'h0, ev});
              chk("R10 irq in sweep", {7'h0, irq}, {7'h0, ev != C_NONE});
            end
    end
    ls_err = 4'h0; ms_delta = 4'h0;

    // R4: trigger levels
    ien = 4'b0001;
    for (int fm = 0; fm < 2; fm++)
      for (int s = 0; s < 4; s++)
        for (int c = 0; c <= 16; c++) begin
          int lvl;
          fifo_mode = fm[0];
          trig_sel = 2'(s);
          rx_count = CNT_W'(c);
          data_ready = (c != 0);
          lvl = (fm == 0) ? 1 : (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
          tick();
          chk("R4 trigger level", {4'h0, irq_code},
              {4'h0, (c != 0 && c >= lvl) ? C_RXD : C_NONE});
        end

    // R5: timeout threshold 4 * 3 = 12
    fifo_mode = 1'b1; trig_sel = 2'd1; rx_count = CNT_W'(1); data_ready = 1'b1;
    frame_time = 12'd3; rx_push = 1'b1; tick(); rx_push = 1'b0;
    for (int n = 1; n <= 16; n++) begin
      tick();
      chk("R5 timeout ramp", {4'h0, irq_code}, {4'h0, (n - 1 >= 12) ? C_TMO : C_NONE});
    end
    rx_pop = 1'b1; tick(); rx_pop = 1'b0; tick();
    chk("R5 pop restarts counter", {4'h0, irq_code}, {4'h0, C_NONE});
    rx_push = 1'b1; tick(); rx_push = 1'b0; data_ready = 1'b0;
    for (int n = 0; n < 20; n++) tick();
    chk("R5 counter holds without data ready", {4'h0, irq_code}, {4'h0, C_NONE});
    data_ready = 1'b1;
    for (int n = 1; n <= 13; n++) begin
      tick();
      if (n == 12) chk("R5 one short of threshold", {4'h0, irq_code}, {4'h0, C_NONE});
      if (n == 13) chk("R5 threshold reached", {4'h0, irq_code}, {4'h0, C_TMO});
    end
    ien = 4'b0000; rx_count = '0; tick(); tick();
    chk("R5 disabled timeout", {4'h0, irq_code}, {4'h0, C_NONE});

    done = 1;
    summary();
    $finish;
  end

endmodule